// File: doc/BRIEF.md
# Comparator Control and Interrupt Unit

This block is the digital side of an analog voltage comparator. It keeps one 8-bit control and status register on a simple register bus and drives the selects for the comparator's two inputs. The raw comparator decision, which may change at any moment, passes through a synchronizer before software can read it. Edges of the synchronized result raise a sticky interrupt flag, and the flag gates an interrupt request.

Software picks which edges count, or asks for none. It can cut the comparator's power, choose the internal reference for the positive input, and steer the synchronized result to a timer's capture trigger. The analog comparator, the reference and the timer are outside the block and appear only as ports.

Register bits, from bit 7 down to bit 0:

| Bit | Field |
|-----|-------|
| 7 | power-off |
| 6 | reference select |
| 5 | live output (read-only) |
| 4 | event flag |
| 3 | interrupt enable |
| 2 | capture route |
| 1:0 | edge mode |

The bus has no handshake. A write takes effect at the clock edge on which `reg_wr` is high. `reg_rdata` always shows the current register contents.

Top module: `cmp_ctrl_unit`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `irq`, `cap_trig`, `pwr_down` and `pos_sel_ref` are all 0.
- R2: A write stores bits 7, 6, 4..0 as described here and ignores bit 5, with two exceptions. Bit 4 follows the rules in R5, and edge-mode bits 1:0 are written as given. `pwr_down` equals bit 7. `pos_sel_ref` equals bit 6, where 1 selects the internal reference and 0 selects the external positive pin.
- R3: Bit 5 shows `cmp_raw` after a 2-flop synchronizer. A level that is stable before clock edge k shows in bit 5 after edge k+1.
- R4: Bit 4 is set one clock after the synchronized output makes a transition that matches the edge mode. The modes are: 00 any transition, 01 none, 10 a 1-to-0 fall, 11 a 0-to-1 rise.
- R5: Bit 4 clears when `irq_ack` is high, or when a write has bit 4 at 1. A write with bit 4 at 0 leaves bit 4 unchanged.
- R6: When a flag-set event and a clear request fall in the same cycle, bit 4 ends up set.
- R7: `irq` is 1 exactly when bit 4, bit 3 and `glb_ie` are all 1.
- R8: `cap_trig` equals the synchronized output (bit 5) when bit 2 is 1, and is 0 otherwise.
- R9: While bit 7 is 1, the synchronizer keeps its value, bit 5 does not change, and no event sets bit 4.
- R10: `neg_use_chan` is 1 and `neg_chan` equals `neg_sel` only when `neg_mux_en` is 1 and `adc_on` is 0. For example, `neg_sel` values 5, 6 and 7 give channels 5, 6 and 7. Otherwise both outputs are 0, which selects the external negative pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmp_raw | input | 1 | Asynchronous comparator result |
| glb_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Timer capture trigger |
| pwr_down | output | 1 | Comparator power-off |
| pos_sel_ref | output | 1 | Positive input select (1 = reference) |
| neg_mux_en | input | 1 | Negative-input mux enable |
| adc_on | input | 1 | Converter enabled |
| neg_sel | input | 3 | Negative channel number |
| neg_use_chan | output | 1 | Negative input taken from a channel |
| neg_chan | output | 3 | Selected negative channel |

## Verification
The assertions assume the following about the inputs:
- `reg_wr`, `reg_wdata`, `irq_ack` and `glb_ie` are synchronous to `clk`.
- `cmp_raw` is the only asynchronous input, and it reaches the logic only through the synchronizer.

The stimulus respects this by changing every input just after a rising edge. `cmp_raw` is allowed to toggle on any cycle, including while the comparator is powered off and across mode changes. Acknowledges are timed directly onto the cycle of a pending event so that the set-over-clear rule is exercised.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_NONE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_RISE = 2'b11
  } edge_mode_e;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_OFF   = 7;
  localparam int unsigned B_REF   = 6;
  localparam int unsigned B_OUT   = 5;
  localparam int unsigned B_FLAG  = 4;
  localparam int unsigned B_IE    = 3;
  localparam int unsigned B_CAP   = 2;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)     chain[0] <= 1'b0;
          else if (!hold) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)     chain[i] <= 1'b0;
          else if (!hold) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q));
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur,
  input  logic       hold,
  input  edge_mode_e mode,
  output logic       evt
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;

  always_comb begin
    evt = 1'b0;
    if (!hold) begin
      unique case (mode)
        EDGE_ANY:  evt = cur ^ prev;
        EDGE_NONE: evt = 1'b0;
        EDGE_FALL: evt = prev & ~cur;
        EDGE_RISE: evt = cur & ~prev;
      endcase
    end
  end

  assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_FALL && evt) |-> !cur);
  assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_RISE && evt) |-> cur);
endmodule

// File: rtl/cmp_ctrl_unit.sv
module cmp_ctrl_unit
  import cmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CHAN_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cmp_raw,
  input  logic              glb_ie,
  input  logic              irq_ack,
  output logic              irq,
  output logic              cap_trig,
  output logic              pwr_down,
  output logic              pos_sel_ref,
  input  logic              neg_mux_en,
  input  logic              adc_on,
  input  logic [CHAN_W-1:0] neg_sel,
  output logic              neg_use_chan,
  output logic [CHAN_W-1:0] neg_chan
);
  logic       off_q, ref_q, flag_q, ie_q, cap_q;
  edge_mode_e mode_q;
  logic       sync_out, evt;
  logic       clr_req;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(off_q), .d(cmp_raw), .q(sync_out)
  );

  cmp_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .cur(sync_out), .hold(off_q),
    .mode(mode_q), .evt(evt)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      off_q  <= 1'b0;
      ref_q  <= 1'b0;
      ie_q   <= 1'b0;
      cap_q  <= 1'b0;
      mode_q <= EDGE_ANY;
    end else if (reg_wr) begin
      off_q  <= reg_wdata[B_OFF];
      ref_q  <= reg_wdata[B_REF];
      ie_q   <= reg_wdata[B_IE];
      cap_q  <= reg_wdata[B_CAP];
      mode_q <= edge_mode_e'(reg_wdata[1:0]);
    end

  assign clr_req = irq_ack | (reg_wr & reg_wdata[B_FLAG]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag_q <= 1'b0;
    else if (evt)     flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;

  assign reg_rdata    = {off_q, ref_q, sync_out, flag_q, ie_q, cap_q, mode_q};
  assign irq          = flag_q & ie_q & glb_ie;
  assign cap_trig     = cap_q & sync_out;
  assign pwr_down     = off_q;
  assign pos_sel_ref  = ref_q;
  assign neg_use_chan = neg_mux_en & ~adc_on;
  assign neg_chan     = neg_use_chan ? neg_sel : '0;

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> reg_rdata[B_FLAG]);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && irq_ack) |=> flag_q);
  assert_flag_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && irq_ack) |=> !flag_q);
  assert_flag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !evt && !irq_ack && !(reg_wr && reg_wdata[B_FLAG])) |=> flag_q);
  assert_no_evt_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !flag_q && !reg_wr) |=> !flag_q);
endmodule

// File: tb/cmp_ctrl_unit_tb.sv
module cmp_ctrl_unit_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, cmp_raw = 0, glb_ie = 0, irq_ack = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, cap_trig, pwr_down, pos_sel_ref, neg_mux_en = 0, adc_on = 0;
  logic [2:0] neg_sel = 0, neg_chan;
  logic neg_use_chan;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_ctrl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_raw(cmp_raw), .glb_ie(glb_ie),
    .irq_ack(irq_ack), .irq(irq), .cap_trig(cap_trig), .pwr_down(pwr_down),
    .pos_sel_ref(pos_sel_ref), .neg_mux_en(neg_mux_en), .adc_on(adc_on),
    .neg_sel(neg_sel), .neg_use_chan(neg_use_chan), .neg_chan(neg_chan)
  );

  // Reference model: history of raw samples and behavioural register state
  bit hist[$];
  bit m_out, m_last, m_flag;
  bit [7:0] m_ctl;

  always @(posedge clk) begin
    bit ev, off;
    if (!rst_n) begin
      hist = {1'b0, 1'b0}; m_out = 0; m_last = 0; m_flag = 0; m_ctl = 0;
    end else begin
      off = m_ctl[7];
      case (m_ctl[1:0])
        2'b00: ev = (m_out != m_last);
        2'b10: ev = (m_last && !m_out);
        2'b11: ev = (!m_last && m_out);
        default: ev = 0;
      endcase
      if (off) ev = 0;
      m_last = m_out;
      if (!off) begin
        hist.push_back(cmp_raw);
        void'(hist.pop_front());
        m_out = hist[0];
      end
      if (ev) m_flag = 1;
      else if (irq_ack || (reg_wr && reg_wdata[4])) m_flag = 0;
      if (reg_wr) m_ctl = reg_wdata & 8'hCF;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit [7:0] er;
    er = m_ctl | {2'b0, m_out, m_flag, 4'b0};
    chk("R2 ctrl bits", reg_rdata & 8'hCF, er & 8'hCF);
    chk("R3 out bit", reg_rdata[5], er[5]);
    chk("R4/R5/R6 flag", reg_rdata[4], er[4]);
    chk("R7 irq", irq, m_flag & m_ctl[3] & glb_ie);
    chk("R8 cap_trig", cap_trig, m_ctl[2] & m_out);
    chk("R2 pwr/ref", {pwr_down, pos_sel_ref}, m_ctl[7:6]);
    chk("R10 neg use", neg_use_chan, neg_mux_en & ~adc_on);
    chk("R10 neg chan", neg_chan, (neg_mux_en & ~adc_on) ? neg_sel : 0);
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(bit [7:0] d);
    reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0; reg_wdata = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R1 reset outs", {irq, cap_trig, pwr_down, pos_sel_ref}, 0);
    tick();
    // R2: all writable bits, bit 5 ignored
    wr(8'hEF); @(negedge clk);
    chk("R2 readback", reg_rdata & 8'hEF, 8'hCF);
    tick(); wr(8'h08); // mode any, ie
    glb_ie = 1;
    // R3 latency: raw rises after edge k, bit5 after edge k+2 (k+1 sample)
    cmp_raw = 1; tick(); @(negedge clk);
    chk("R3 not yet", reg_rdata[5], 0);
    tick(); @(negedge clk);
    chk("R3 visible", reg_rdata[5], 1);
    tick(); @(negedge clk);
    chk("R4 any edge sets flag", reg_rdata[4], 1);
    chk("R7 irq on", irq, 1);
    // R5 write zero keeps, write one clears, ack clears
    tick(); wr(8'h08); @(negedge clk);
    chk("R5 write0 keeps", reg_rdata[4], 1);
    tick(); wr(8'h18); @(negedge clk);
    chk("R5 write1 clears", reg_rdata[4], 0);
    // R6: ack in cycle of pending event
    cmp_raw = 0; tick(2); irq_ack = 1; tick(); irq_ack = 0; @(negedge clk);
    chk("R6 set wins", reg_rdata[4], 1);
    tick(); irq_ack = 1; tick(); irq_ack = 0; @(negedge clk);
    chk("R5 ack clears", reg_rdata[4], 0);
    // R4 rise mode ignores fall
    tick(); wr(8'h0B); cmp_raw = 1; tick(4); wr(8'h1B); cmp_raw = 0; tick(4); @(negedge clk);
    chk("R4 rise mode ignores fall", reg_rdata[4], 0);
    // R9 power-off: hold and no event
    tick(); wr(8'h88); cmp_raw = 1; tick(5); @(negedge clk);
    chk("R9 out held", reg_rdata[5], 0);
    chk("R9 no flag", reg_rdata[4], 0);
    // R8 + R10 directed
    tick(); wr(8'h04); tick(4); @(negedge clk);
    chk("R8 cap follows", cap_trig, 1);
    neg_mux_en = 1; neg_sel = 3'd6; #1;
    chk("R10 chan 6", {neg_use_chan, neg_chan}, 4'b1110);
    adc_on = 1; #1;
    chk("R10 adc on", neg_use_chan, 0);
    tick();
    // Random mix checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      cmp_raw = $urandom_range(0, 1);
      glb_ie = $urandom_range(0, 1);
      irq_ack = ($urandom_range(0, 7) == 0);
      neg_mux_en = $urandom_range(0, 1);
      adc_on = $urandom_range(0, 1);
      neg_sel = 3'($urandom_range(0, 7));
      reg_wr = ($urandom_range(0, 9) == 0);
      reg_wdata = 8'($urandom_range(0, 255)) & (($urandom_range(0, 3) == 0) ? 8'hFF : 8'h7F);
      tick();
    end
    reg_wr = 0; irq_ack = 0;
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule